// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a record of loads that were hoisted above stores whose addresses were not known to be disjoint. Each hoisted load claims a slot chosen by its destination register number. The slot holds the register number, the byte address, a small type tag and the access width. Every store that retires is compared against all live slots at once, and any slot whose byte range touches the store's range is dropped.

Before the hoisted value is used, a check names the register and the expected type tag. The table answers in the same cycle. A hit means the speculation held. A miss raises a recover flag, so the pipeline can re-execute the load.

Slots are also lost when a later hoisted load targets the same register, when a different register maps to the same slot, and when a context-switch flush clears the whole table.

Top module: `spec_load_table`

## Requirements
- R1: After reset every slot is empty, so any check misses and raises chkRecover.
- R2: A hoisted load to register r (7 bits) fills slot r[3:0] and stores the full r as a tag. From the next cycle on, a check of r with the same type hits. A check of a register that shares r[3:0] but has different upper bits misses.
- R3: A check whose type tag differs from the stored type misses.
- R4: chkHit and chkRecover are both low when chkValid is low. When chkValid is high, exactly one of them is high. A check leaves the table unchanged, so repeating a check gives the same answer.
- R5: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A store kills a live slot when (stAddr < slotAddr + slotBytes) and (slotAddr < stAddr + stBytes). Addresses are compared without wrap-around.
- R6: A store whose byte range only abuts a slot's range, on either side, leaves the slot live.
- R7: A new hoisted load to the same register replaces the slot. The new type and address govern, so a store to the old address no longer kills the slot.
- R8: Capacity eviction: a hoisted load to a different register that maps to the same slot evicts the old register, and checks of the old register then miss.
- R9: flushIn empties every slot on the next edge. It takes priority over a hoisted load in the same cycle, and that load is lost.
- R10: When a store and a hoisted load arrive in the same cycle, the store kills are applied first and the new slot is written afterwards. The new slot survives even if it overlaps the store, while other overlapping slots die.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| flushIn | input | 1 | Context-switch clear of all slots |
| ldValid | input | 1 | Hoisted load retires this cycle |
| ldReg | input | 7 | Destination register of the hoisted load |
| ldAddr | input | 32 | Byte address of the hoisted load |
| ldType | input | 2 | Type tag of the hoisted load |
| ldSize | input | 2 | Size code of the hoisted load (1/2/4/8 bytes) |
| stValid | input | 1 | Store retires this cycle |
| stAddr | input | 32 | Byte address of the store |
| stSize | input | 2 | Size code of the store |
| chkValid | input | 1 | Check request this cycle |
| chkReg | input | 7 | Register being checked |
| chkType | input | 2 | Expected type tag |
| chkHit | output | 1 | Check found a live, matching slot |
| chkRecover | output | 1 | Check missed; recovery needed |

## Verification
Stores are placed exactly abutting a slot below and above it, overlapping by a single byte, and straddling the end of an 8-byte slot. These cases separate a correct overlap test from one that is off by one or that ignores the width. Register pairs that share the low index bits separate tag comparison from index-only lookup. Pairs of loads to the same register with different types and addresses show whether a slot is truly replaced. Same-cycle store-plus-load and flush-plus-load patterns pin down the ordering of kill, allocation and flush.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam int SltIdxW  = 4;
  localparam int SltDepth = 1 << SltIdxW;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } accSize_e;

  // Strobes from control to the slot storage
  typedef struct packed {
    logic                clearAll;
    logic                allocEn;
    logic [SltIdxW-1:0]  allocIdx;
    logic [SltDepth-1:0] killVec;
  } tblStrobe_t;

  function automatic logic [3:0] sizeBytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/slt_entries.sv
module slt_entries
  import slt_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  tblStrobe_t          strobe,
  input  logic [REG_W-1:0]    wrTag,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [TYPE_W-1:0]   wrType,
  input  logic [1:0]          wrSize,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic [1:0]          stSize,
  input  logic [SltIdxW-1:0]  rdIdx,
  output logic [SltDepth-1:0] ovlVec,
  output logic                rdValid,
  output logic [REG_W-1:0]    rdTag,
  output logic [TYPE_W-1:0]   rdType
);
  localparam int EXT_W = ADDR_W + 1;

  logic [SltDepth-1:0] vld;
  logic [REG_W-1:0]    tagArr  [SltDepth];
  logic [ADDR_W-1:0]   addrArr [SltDepth];
  logic [TYPE_W-1:0]   typeArr [SltDepth];
  logic [1:0]          sizeArr [SltDepth];

  logic [EXT_W-1:0] stLo;
  logic [EXT_W-1:0] stHi;

  assign stLo = {1'b0, stAddr};
  assign stHi = stLo + EXT_W'(sizeBytes(stSize));

  for (genvar g = 0; g < SltDepth; g++) begin : gSlot
    logic [EXT_W-1:0] entLo;
    logic [EXT_W-1:0] entHi;
    logic             wrHere;

    assign entLo     = {1'b0, addrArr[g]};
    assign entHi     = entLo + EXT_W'(sizeBytes(sizeArr[g]));
    assign ovlVec[g] = vld[g] && (stLo < entHi) && (entLo < stHi);
    assign wrHere    = strobe.allocEn && (strobe.allocIdx == SltIdxW'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld[g]     <= 1'b0;
        tagArr[g]  <= '0;
        addrArr[g] <= '0;
        typeArr[g] <= '0;
        sizeArr[g] <= '0;
      end else if (strobe.clearAll) begin
        vld[g] <= 1'b0;
      end else if (wrHere) begin
        vld[g]     <= 1'b1;
        tagArr[g]  <= wrTag;
        addrArr[g] <= wrAddr;
        typeArr[g] <= wrType;
        sizeArr[g] <= wrSize;
      end else if (strobe.killVec[g]) begin
        vld[g] <= 1'b0;
      end
    end
  end

  assign rdValid = vld[rdIdx];
  assign rdTag   = tagArr[rdIdx];
  assign rdType  = typeArr[rdIdx];
endmodule

// File: rtl/slt_ctrl.sv
module slt_ctrl
  import slt_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int TYPE_W = 2
) (
  input  logic                flushIn,
  input  logic                ldValid,
  input  logic [REG_W-1:0]    ldReg,
  input  logic                stValid,
  input  logic [SltDepth-1:0] ovlVec,
  input  logic                chkValid,
  input  logic [REG_W-1:0]    chkReg,
  input  logic [TYPE_W-1:0]   chkType,
  input  logic                rdValid,
  input  logic [REG_W-1:0]    rdTag,
  input  logic [TYPE_W-1:0]   rdType,
  output tblStrobe_t          strobe,
  output logic [SltIdxW-1:0]  rdIdx,
  output logic                chkHit,
  output logic                chkRecover
);
  logic slotMatch;

  always_comb begin
    strobe.clearAll = flushIn;
    strobe.allocEn  = ldValid;
    strobe.allocIdx = ldReg[SltIdxW-1:0];
    strobe.killVec  = stValid ? ovlVec : '0;
  end

  assign rdIdx      = chkReg[SltIdxW-1:0];
  assign slotMatch  = rdValid && (rdTag == chkReg) && (rdType == chkType);
  assign chkHit     = chkValid && slotMatch;
  assign chkRecover = chkValid && !slotMatch;
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table
  import slt_pkg::*;
#(
  parameter int REG_W  = 7,
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushIn,
  input  logic              ldValid,
  input  logic [REG_W-1:0]  ldReg,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [TYPE_W-1:0] ldType,
  input  logic [1:0]        ldSize,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic              chkValid,
  input  logic [REG_W-1:0]  chkReg,
  input  logic [TYPE_W-1:0] chkType,
  output logic              chkHit,
  output logic              chkRecover
);
  tblStrobe_t          strobe;
  logic [SltDepth-1:0] ovlVec;
  logic [SltIdxW-1:0]  rdIdx;
  logic                rdValid;
  logic [REG_W-1:0]    rdTag;
  logic [TYPE_W-1:0]   rdType;

  slt_ctrl #(.REG_W(REG_W), .TYPE_W(TYPE_W)) uCtrl (
    .flushIn    (flushIn),
    .ldValid    (ldValid),
    .ldReg      (ldReg),
    .stValid    (stValid),
    .ovlVec     (ovlVec),
    .chkValid   (chkValid),
    .chkReg     (chkReg),
    .chkType    (chkType),
    .rdValid    (rdValid),
    .rdTag      (rdTag),
    .rdType     (rdType),
    .strobe     (strobe),
    .rdIdx      (rdIdx),
    .chkHit     (chkHit),
    .chkRecover (chkRecover)
  );

  slt_entries #(.REG_W(REG_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) uEntries (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrTag   (ldReg),
    .wrAddr  (ldAddr),
    .wrType  (ldType),
    .wrSize  (ldSize),
    .stAddr  (stAddr),
    .stSize  (stSize),
    .rdIdx   (rdIdx),
    .ovlVec  (ovlVec),
    .rdValid (rdValid),
    .rdTag   (rdTag),
    .rdType  (rdType)
  );
endmodule

// File: rtl/slt_checker.sv
module slt_checker #(
  parameter int REG_W  = 7,
  parameter int TYPE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              flushIn,
  input logic              ldValid,
  input logic [REG_W-1:0]  ldReg,
  input logic [TYPE_W-1:0] ldType,
  input logic              chkValid,
  input logic [REG_W-1:0]  chkReg,
  input logic [TYPE_W-1:0] chkType,
  input logic              chkHit,
  input logic              chkRecover
);
  logic              primed;
  logic              prevAlloc;
  logic              prevFlush;
  logic [REG_W-1:0]  prevReg;
  logic [TYPE_W-1:0] prevType;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed    <= 1'b0;
      prevAlloc <= 1'b0;
      prevFlush <= 1'b0;
      prevReg   <= '0;
      prevType  <= '0;
    end else begin
      primed    <= 1'b1;
      prevAlloc <= ldValid && !flushIn;
      prevFlush <= flushIn;
      prevReg   <= ldReg;
      prevType  <= ldType;
    end
  end

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    (!primed && chkValid) |-> !chkHit);

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |-> (!chkHit && !chkRecover));

  a_r4_one_answer: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |-> (chkHit != chkRecover));

  // R10: the previous-cycle load is visible whatever store came with it
  a_r2_alloc_visible: assert property (@(posedge clk) disable iff (!rstN)
    (primed && prevAlloc && chkValid && chkReg == prevReg && chkType == prevType) |-> chkHit);

  a_r3_type_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (primed && prevAlloc && chkValid && chkReg == prevReg && chkType != prevType) |-> !chkHit);

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    (primed && prevFlush) |-> !chkHit);
endmodule

bind spec_load_table slt_checker #(.REG_W(REG_W), .TYPE_W(TYPE_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .flushIn    (flushIn),
  .ldValid    (ldValid),
  .ldReg      (ldReg),
  .ldType     (ldType),
  .chkValid   (chkValid),
  .chkReg     (chkReg),
  .chkType    (chkType),
  .chkHit     (chkHit),
  .chkRecover (chkRecover)
);

// File: tb/tb_spec_load_table.sv
`timescale 1ns/1ps
module tb_spec_load_table;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushIn = 1'b0;
  logic        ldValid = 1'b0;
  logic [6:0]  ldReg = '0;
  logic [31:0] ldAddr = '0;
  logic [1:0]  ldType = '0;
  logic [1:0]  ldSize = '0;
  logic        stValid = 1'b0;
  logic [31:0] stAddr = '0;
  logic [1:0]  stSize = '0;
  logic        chkValid = 1'b0;
  logic [6:0]  chkReg = '0;
  logic [1:0]  chkType = '0;
  logic        chkHit;
  logic        chkRecover;

  int nTests = 0;
  int nFails = 0;

  typedef struct {
    bit    hit;
    string req;
  } exp_t;
  exp_t expQ[$];

  always #2 clk = ~clk;

  spec_load_table dut (
    .clk(clk), .rstN(rstN), .flushIn(flushIn),
    .ldValid(ldValid), .ldReg(ldReg), .ldAddr(ldAddr), .ldType(ldType), .ldSize(ldSize),
    .stValid(stValid), .stAddr(stAddr), .stSize(stSize),
    .chkValid(chkValid), .chkReg(chkReg), .chkType(chkType),
    .chkHit(chkHit), .chkRecover(chkRecover)
  );

  task automatic endCycle();
    @(posedge clk);
    #1;
    flushIn  = 1'b0;
    ldValid  = 1'b0;
    stValid  = 1'b0;
    chkValid = 1'b0;
  endtask

  task automatic setLoad(input int r, input int a, input int t, input int s);
    ldValid = 1'b1;
    ldReg   = 7'(r);
    ldAddr  = 32'(a);
    ldType  = 2'(t);
    ldSize  = 2'(s);
  endtask

  task automatic setStore(input int a, input int s);
    stValid = 1'b1;
    stAddr  = 32'(a);
    stSize  = 2'(s);
  endtask

  task automatic doLoad(input int r, input int a, input int t, input int s);
    setLoad(r, a, t, s);
    endCycle();
  endtask

  task automatic doStore(input int a, input int s);
    setStore(a, s);
    endCycle();
  endtask

  task automatic doCheck(input int r, input int t, input bit expHit, input string req);
    exp_t e;
    e.hit = expHit;
    e.req = req;
    expQ.push_back(e);
    chkValid = 1'b1;
    chkReg   = 7'(r);
    chkType  = 2'(t);
    endCycle();
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (rstN && chkValid) begin
      nTests++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL unexpected check result: hit=%0b", chkHit);
      end else begin
        e = expQ.pop_front();
        if (chkHit !== e.hit || chkRecover !== !e.hit) begin
          nFails++;
          $display("FAIL %s reg=%0d: hit/recover actual %0b/%0b expected %0b/%0b",
                   e.req, chkReg, chkHit, chkRecover, e.hit, !e.hit);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    doCheck(3, 0, 1'b0, "R1");
    doCheck(19, 1, 1'b0, "R1");

    doLoad(3, 'h100, 1, 2);
    doCheck(3, 1, 1'b1, "R2");
    doCheck(3, 1, 1'b1, "R4");
    doCheck(3, 2, 1'b0, "R3");
    doCheck(19, 1, 1'b0, "R2");

    // R4: idle cycle with a live slot
    @(negedge clk);
    nTests++;
    if (chkHit !== 1'b0 || chkRecover !== 1'b0) begin
      nFails++;
      $display("FAIL R4 idle outputs actual %0b/%0b expected 0/0", chkHit, chkRecover);
    end
    endCycle();

    doStore('h104, 2);
    doCheck(3, 1, 1'b1, "R6");
    doStore('hFC, 2);
    doCheck(3, 1, 1'b1, "R6");
    doStore('h103, 0);
    doCheck(3, 1, 1'b0, "R5");

    doLoad(5, 'h200, 0, 3);
    doStore('h1FE, 1);
    doCheck(5, 0, 1'b1, "R6");
    doStore('h207, 0);
    doCheck(5, 0, 1'b0, "R5");
    doLoad(5, 'h200, 0, 3);
    doStore('h1FF, 1);
    doCheck(5, 0, 1'b0, "R5");

    doLoad(7, 'h300, 0, 2);
    doLoad(7, 'h400, 3, 2);
    doCheck(7, 0, 1'b0, "R7");
    doStore('h300, 3);
    doCheck(7, 3, 1'b1, "R7");
    doStore('h402, 0);
    doCheck(7, 3, 1'b0, "R7");

    doLoad(9, 'h500, 0, 2);
    doLoad(73, 'h600, 0, 2);
    doCheck(9, 0, 1'b0, "R8");
    doCheck(73, 0, 1'b1, "R8");

    doLoad(1, 'h10, 0, 0);
    doLoad(2, 'h20, 0, 0);
    flushIn = 1'b1;
    endCycle();
    doCheck(1, 0, 1'b0, "R9");
    doCheck(2, 0, 1'b0, "R9");
    doCheck(73, 0, 1'b0, "R9");
    setLoad(4, 'h40, 0, 0);
    flushIn = 1'b1;
    endCycle();
    doCheck(4, 0, 1'b0, "R9");

    doLoad(10, 'h700, 0, 2);
    setStore('h700, 2);
    setLoad(11, 'h700, 0, 2);
    endCycle();
    doCheck(10, 0, 1'b0, "R10");
    doCheck(11, 0, 1'b1, "R10");

    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL %0d expected results never observed", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule